// File: doc/BRIEF.md
# Block-Staggered Pipelined Integer ALU

This block is a 32-bit integer ALU built as a chain of eight 4-bit slices. Each slice has a register at its output. An operation does not enter all at once. Its lowest operand nibble is presented in the issue cycle, and each higher nibble follows one cycle after the nibble below it. Each slice registers its 4-bit result, its carry and the control word of the operation it just handled, and passes them to the slice above. A new operation can therefore start in every cycle, and each slice always works under the opcode of its own operation.

The result leaves the block staggered in the same way. Each result nibble can be routed straight back into the matching slice as operand A of the operation issued one cycle later. A chain of dependent operations then runs at one per cycle, because no operation waits for the full 32-bit value of the one before it.

Set-less-than needs the sign and overflow of the top slice, so its answer bit only exists at the top of the chain. That bit is delivered on a separate output, together with the top result nibble. For the one cycle after a set-less-than issues, the block refuses a forwarding issue.

Top module: `skew_alu`

## Requirements
- R1: The block samples operand nibble k (bits 4k+3..4k of `a_skew` and `b_skew`) for an operation issued in cycle t during cycle t+k. The matching result nibble appears on `res_skew`, with `res_vld[k]` high, during cycle t+k+1.
- R2: ADD (`in_op` = 0) returns A+B modulo 2^32. Carries ripple correctly across every slice boundary.
- R3: SUB (`in_op` = 1) returns A−B modulo 2^32, computed as A plus inverted B plus a carry-in of one at the lowest slice.
- R4: AND (2), OR (3), XOR (4) and NOR (5) return the bitwise function of A and B.
- R5: SLT (`in_op` = 6) drives all of its result nibbles as zero. In the cycle that result nibble 7 appears, `slt_vld` is high and `slt_bit` is 1 exactly when A is less than B as signed 32-bit values, including operand pairs whose difference overflows.
- R6: Operations with different opcodes issued in back-to-back cycles each produce their own correct result in every nibble.
- R7: When `in_fwd` is high with an accepted issue, operand A is the result of the operation issued in the previous cycle, and `a_skew` is ignored for that operation.
- R8: `issue_hold` is high in the cycle after an accepted SLT issue. An issue with `in_fwd` high in that cycle is dropped: none of its `res_vld` bits ever rises.
- R9: While `rst_n` is low, `res_vld`, `res_skew`, `slt_vld`, `slt_bit` and `issue_hold` are all zero.
- R10: Opcode 7 is accepted and produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 3 | Opcode of the issuing operation |
| in_fwd | input | 1 | Take operand A from the previous operation's result |
| a_skew | input | 32 | Operand A nibbles, nibble k belonging to the operation issued k cycles ago |
| b_skew | input | 32 | Operand B nibbles, staggered as `a_skew` |
| res_skew | output | 32 | Result nibbles, nibble k belonging to the operation issued k+1 cycles ago |
| res_vld | output | 8 | Per-nibble result valid |
| slt_bit | output | 1 | Set-less-than answer bit |
| slt_vld | output | 1 | `slt_bit` is valid this cycle |
| issue_hold | output | 1 | A forwarding issue this cycle will be dropped |

## Verification
Carry chains that run through every slice, such as all-ones plus one and zero minus one, show whether the carry reaches each higher slice exactly one cycle late. Signed comparisons across the overflow boundary separate a correct sign-and-overflow test from a plain check of the sign bit. Dependent chains that forward on every cycle, with a deliberately misleading `a_skew`, show whether each slice takes the previous result nibble at the right cycle. A long run of mixed, back-to-back random opcodes catches any slice that uses the opcode of a neighbouring operation.

// File: rtl/skew_alu_pkg.sv
package skew_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_NOR  = 3'd5,
      OP_SLT  = 3'd6,
      OP_NONE = 3'd7
   } alu_op_e;

   // control word travelling up the slice chain with its operation
   typedef struct packed {
      logic    valid;
      alu_op_e op;
      logic    fwd;
   } blk_ctl_t;

   function automatic logic op_inverts_b(alu_op_e o);
      return (o == OP_SUB) || (o == OP_SLT);
   endfunction

   function automatic logic op_is_arith(alu_op_e o);
      return (o == OP_ADD) || (o == OP_SUB) || (o == OP_SLT);
   endfunction

endpackage

// File: rtl/skew_alu_blk.sv
module skew_alu_blk
   import skew_alu_pkg::*;
#(
   parameter int BLK_W = 4
) (
   input  alu_op_e          op,
   input  logic [BLK_W-1:0] a,
   input  logic [BLK_W-1:0] b,
   input  logic             cin,
   output logic [BLK_W-1:0] r,
   output logic             cout,
   output logic             lt
);

   logic [BLK_W-1:0] bx;
   logic [BLK_W:0]   sum;
   logic [BLK_W-1:0] low;
   logic             c_msb;

   always_comb begin
      bx    = op_inverts_b(op) ? ~b : b;
      sum   = {1'b0, a} + {1'b0, bx} + {{BLK_W{1'b0}}, cin};
      low   = {1'b0, a[BLK_W-2:0]} + {1'b0, bx[BLK_W-2:0]} + {{(BLK_W-1){1'b0}}, cin};
      c_msb = low[BLK_W-1];
      // signed less-than: sign of difference corrected by overflow
      lt    = sum[BLK_W-1] ^ c_msb ^ sum[BLK_W];
      cout  = op_is_arith(op) ? sum[BLK_W] : 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: r = sum[BLK_W-1:0];
         OP_AND:         r = a & b;
         OP_OR:          r = a | b;
         OP_XOR:         r = a ^ b;
         OP_NOR:         r = ~(a | b);
         default:        r = '0;
      endcase
   end

endmodule

// File: rtl/skew_alu_stage.sv
module skew_alu_stage
   import skew_alu_pkg::*;
#(
   parameter int BLK_W  = 4,
   parameter bit IS_TOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  blk_ctl_t         ctl_i,
   input  logic [BLK_W-1:0] a_ext,
   input  logic [BLK_W-1:0] b_ext,
   input  logic             cin,
   output blk_ctl_t         ctl_o,
   output logic [BLK_W-1:0] r_o,
   output logic             link_o
);

   blk_ctl_t         ctl_q;
   logic [BLK_W-1:0] r_q;
   logic             link_q;
   logic [BLK_W-1:0] a_use;
   logic [BLK_W-1:0] r_d;
   logic             cout_d;
   logic             lt_d;
   logic             link_d;

   // forward path: own registered nibble belongs to the previous issue
   assign a_use = ctl_i.fwd ? r_q : a_ext;

   skew_alu_blk #(.BLK_W(BLK_W)) u_blk (
      .op   (ctl_i.op),
      .a    (a_use),
      .b    (b_ext),
      .cin  (cin),
      .r    (r_d),
      .cout (cout_d),
      .lt   (lt_d)
   );

   generate
      if (IS_TOP) begin : g_top
         assign link_d = (ctl_i.op == OP_SLT) ? lt_d : 1'b0;
      end else begin : g_mid
         assign link_d = cout_d;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         r_q    <= '0;
         link_q <= 1'b0;
      end else begin
         ctl_q  <= ctl_i;
         r_q    <= ctl_i.valid ? r_d : '0;
         link_q <= ctl_i.valid ? link_d : 1'b0;
      end
   end

   assign ctl_o  = ctl_q;
   assign r_o    = r_q;
   assign link_o = link_q;

   assert_slt_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.valid && ctl_q.op == OP_SLT) |-> (r_q == '0));

   assert_link_arith_R2: assert property (@(posedge clk) disable iff (!rst_n)
      link_q |-> (ctl_q.valid && op_is_arith(ctl_q.op)));

endmodule

// File: rtl/skew_alu.sv
module skew_alu
   import skew_alu_pkg::*;
#(
   parameter  int BLK_W = 4,
   parameter  int N_BLK = 8,
   localparam int W     = BLK_W * N_BLK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_op,
   input  logic             in_fwd,
   input  logic [W-1:0]     a_skew,
   input  logic [W-1:0]     b_skew,
   output logic [W-1:0]     res_skew,
   output logic [N_BLK-1:0] res_vld,
   output logic             slt_bit,
   output logic             slt_vld,
   output logic             issue_hold
);

   generate
      if (BLK_W < 2) begin : g_bad_blk
         $error("skew_alu: BLK_W must be at least 2");
      end
      if (N_BLK < 2) begin : g_bad_cnt
         $error("skew_alu: N_BLK must be at least 2");
      end
   endgenerate

   blk_ctl_t         ctl_in;
   blk_ctl_t         ctl_o [N_BLK];
   logic [N_BLK-1:0] link;
   logic             accept;

   assign issue_hold = ctl_o[0].valid && (ctl_o[0].op == OP_SLT);
   assign accept     = in_valid && !(in_fwd && issue_hold);

   always_comb begin
      ctl_in.valid = accept;
      ctl_in.op    = alu_op_e'(in_op);
      ctl_in.fwd   = accept && in_fwd;
   end

   genvar k;
   generate
      for (k = 0; k < N_BLK; k++) begin : g_stage
         blk_ctl_t ctl_k;
         logic     cin_k;
         if (k == 0) begin : g_first
            assign ctl_k = ctl_in;
            assign cin_k = accept && op_inverts_b(ctl_in.op);
         end else begin : g_next
            assign ctl_k = ctl_o[k-1];
            assign cin_k = link[k-1];
         end

         skew_alu_stage #(.BLK_W(BLK_W), .IS_TOP(k == N_BLK-1)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_i  (ctl_k),
            .a_ext  (a_skew[k*BLK_W +: BLK_W]),
            .b_ext  (b_skew[k*BLK_W +: BLK_W]),
            .cin    (cin_k),
            .ctl_o  (ctl_o[k]),
            .r_o    (res_skew[k*BLK_W +: BLK_W]),
            .link_o (link[k])
         );

         assign res_vld[k] = ctl_o[k].valid;

         if (k > 0) begin : g_chk
            assert_skew_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
               res_vld[k] |-> $past(res_vld[k-1]));
            assert_fwd_travel_R7: assert property (@(posedge clk) disable iff (!rst_n)
               ctl_o[k].fwd |-> ctl_o[k].valid);
         end
      end
   endgenerate

   assign slt_vld = ctl_o[N_BLK-1].valid && (ctl_o[N_BLK-1].op == OP_SLT);
   assign slt_bit = link[N_BLK-1];

   assert_no_fwd_after_slt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[0].valid && ctl_o[0].fwd) |-> !$past(issue_hold));

   assert_slt_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slt_bit |-> slt_vld);

endmodule

// File: tb/skew_alu_test.sv
`timescale 1ns/1ps
module skew_alu_test;

   localparam int NB  = 8;
   localparam int W   = 32;
   localparam int MAXS = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_op = 3'd0;
   logic          in_fwd = 1'b0;
   logic [W-1:0]  a_skew = '0;
   logic [W-1:0]  b_skew = '0;
   logic [W-1:0]  res_skew;
   logic [NB-1:0] res_vld;
   logic          slt_bit;
   logic          slt_vld;
   logic          issue_hold;

   always #2 clk = ~clk;

   skew_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_fwd(in_fwd),
      .a_skew(a_skew), .b_skew(b_skew), .res_skew(res_skew), .res_vld(res_vld),
      .slt_bit(slt_bit), .slt_vld(slt_vld), .issue_hold(issue_hold)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int ns = 0;

   logic        s_v  [MAXS];
   logic [2:0]  s_op [MAXS];
   logic [31:0] s_a  [MAXS];
   logic [31:0] s_b  [MAXS];
   logic        s_f  [MAXS];
   logic        s_acc[MAXS];
   logic [31:0] s_r  [MAXS];
   logic        s_lt [MAXS];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // behavioural reference, opcode codes as stated in the requirements
   function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return ~(a | b);
         default: return 32'h0;
      endcase
   endfunction

   task automatic add_slot(input logic v, input logic [2:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic f);
      logic hold;
      logic [31:0] ea;
      hold = (ns > 0) && s_acc[ns-1] && (s_op[ns-1] == 3'd6);
      s_v[ns]   = v;
      s_op[ns]  = op;
      s_a[ns]   = a;
      s_b[ns]   = b;
      s_f[ns]   = f;
      s_acc[ns] = v && !(f && hold);
      ea        = (f && ns > 0) ? s_r[ns-1] : a;
      s_r[ns]   = s_acc[ns] ? ref_alu(op, ea, b) : 32'h0;
      s_lt[ns]  = s_acc[ns] && (op == 3'd6) && ($signed(ea) < $signed(b));
      ns++;
   endtask

   task automatic build();
      // R2 carry through every slice
      add_slot(1, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0);
      add_slot(1, 0, 32'h0FFF_FFFF, 32'h0000_0001, 0);
      add_slot(1, 0, 32'h1234_5678, 32'h8765_4321, 0);
      // R3
      add_slot(1, 1, 32'h0000_0000, 32'h0000_0001, 0);
      add_slot(1, 1, 32'h1234_5678, 32'h1234_5678, 0);
      add_slot(1, 1, 32'h8000_0000, 32'h7FFF_FFFF, 0);
      // R4 / R6 back-to-back different ops
      add_slot(1, 2, 32'hF0F0_A5A5, 32'hFF00_3C3C, 0);
      add_slot(1, 3, 32'hF0F0_A5A5, 32'hFF00_3C3C, 0);
      add_slot(1, 4, 32'hF0F0_A5A5, 32'hFF00_3C3C, 0);
      add_slot(1, 5, 32'hF0F0_A5A5, 32'hFF00_3C3C, 0);
      // R10
      add_slot(1, 7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
      // R5 signed compare incl. overflow
      add_slot(1, 6, 32'h8000_0000, 32'h0000_0001, 0);
      add_slot(1, 0, 32'h0000_0003, 32'h0000_0004, 0);
      add_slot(1, 6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
      add_slot(1, 0, 32'h0000_0003, 32'h0000_0004, 0);
      add_slot(1, 6, 32'h0000_0005, 32'h0000_0005, 0);
      add_slot(1, 0, 32'h0000_0003, 32'h0000_0004, 0);
      add_slot(1, 6, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 0);
      add_slot(0, 0, 32'h0, 32'h0, 0);
      // R7 forwarding chain with misleading external A
      add_slot(1, 0, 32'h0000_0001, 32'h0000_0001, 0);
      add_slot(1, 0, 32'hDEAD_BEEF, 32'h0000_0003, 1);
      add_slot(1, 1, 32'hDEAD_BEEF, 32'h0000_0007, 1);
      add_slot(1, 4, 32'hDEAD_BEEF, 32'h5555_5555, 1);
      add_slot(1, 5, 32'hDEAD_BEEF, 32'h0F0F_0000, 1);
      add_slot(1, 0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1);
      // R8 forwarding right after SLT is dropped
      add_slot(1, 6, 32'h0000_0001, 32'h0000_0002, 0);
      add_slot(1, 0, 32'h1111_1111, 32'h2222_2222, 1);
      add_slot(1, 0, 32'h1111_1111, 32'h2222_2222, 0);
      add_slot(1, 6, 32'h0000_0009, 32'h0000_0002, 0);
      add_slot(1, 3, 32'h0000_0000, 32'h0000_0001, 0);
      add_slot(1, 0, 32'h0000_0010, 32'h0000_0001, 1);
      // mixed random traffic
      while (ns < 260) begin
         logic v, f;
         logic [2:0] op;
         v  = ($urandom % 8) != 0;
         op = 3'($urandom % 8);
         f  = s_acc[ns-1] && (s_op[ns-1] != 3'd6) && (($urandom % 2) == 1);
         if (s_acc[ns-1] && s_op[ns-1] == 3'd6 && ($urandom % 4) == 0) f = 1'b1;
         add_slot(v, op, $urandom, $urandom, f);
      end
   endtask

   initial begin
      build();
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 res_vld", {24'h0, res_vld}, 32'h0);
      check("R9 res_skew", res_skew, 32'h0);
      check("R9 slt", {30'h0, slt_vld, slt_bit}, 32'h0);
      check("R9 issue_hold", {31'h0, issue_hold}, 32'h0);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < ns + NB + 2; cyc++) begin
         if (cyc > 0) @(negedge clk);
         // outputs now hold the work done in cycle cyc-1
         for (int k = 0; k < NB; k++) begin
            int s;
            logic ev;
            s  = cyc - 1 - k;
            ev = (s >= 0 && s < ns) ? s_acc[s] : 1'b0;
            check($sformatf("R1/R8 res_vld[%0d] slot %0d", k, s), {31'h0, res_vld[k]}, {31'h0, ev});
            if (ev)
               check($sformatf("R1-blk%0d R2 R3 R4 R6 R7 R10 slot %0d op %0d", k, s, s_op[s]),
                     {28'h0, res_skew[4*k +: 4]}, {28'h0, s_r[s][4*k +: 4]});
            if (k == NB-1) begin
               logic esv;
               esv = ev && (s_op[s] == 3'd6);
               check($sformatf("R5 slt_vld slot %0d", s), {31'h0, slt_vld}, {31'h0, esv});
               if (esv)
                  check($sformatf("R5 slt_bit slot %0d", s), {31'h0, slt_bit}, {31'h0, s_lt[s]});
            end
         end
         check("R8 issue_hold", {31'h0, issue_hold},
               {31'h0, (cyc > 0 && cyc - 1 < ns) ? (s_acc[cyc-1] && s_op[cyc-1] == 3'd6) : 1'b0});
         // drive the inputs of cycle cyc
         in_valid = (cyc < ns) ? s_v[cyc]  : 1'b0;
         in_op    = (cyc < ns) ? s_op[cyc] : 3'd0;
         in_fwd   = (cyc < ns) ? s_f[cyc]  : 1'b0;
         for (int k = 0; k < NB; k++) begin
            int s;
            s = cyc - k;
            a_skew[4*k +: 4] = (s >= 0 && s < ns) ? s_a[s][4*k +: 4] : 4'h0;
            b_skew[4*k +: 4] = (s >= 0 && s < ns) ? s_b[s][4*k +: 4] : 4'h0;
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule